// File: doc/BRIEF.md
# Per-ID Response Ordering Monitor

This block is a passive observer on one AXI4 port. It watches the read address, read data, write address and write response channels. It raises an error when a response arrives out of order within its own ID. Two independent trackers run side by side, one for reads and one for writes. Each holds a small FIFO per ID of the transaction labels that are still outstanding, kept in the order the addresses were accepted.

Every request carries a monitor label (`*_tag`), for example sequence bits on a user sideband, and its response echoes that label back. When a response arrives, its label is compared with the oldest outstanding label for that ID in the same direction. The monitor never compares one ID against another. It also never compares reads against writes, because the two ID spaces are unrelated even when the numbers are equal.

All error outputs are registered. A violation seen at clock edge N shows up as a one-cycle `err_valid` pulse from edge N onward.

Top module: `axi_order_checker`

## Requirements
- R1: Reads sharing an ID whose last beats return in address order raise no error. A last read beat whose tag differs from the oldest outstanding read tag of that ID reports code 1 (order), with `err_is_write`=0 and `err_id` set to that ID.
- R2: Writes sharing an ID whose B responses return in address order raise no error. A B response whose tag differs from the oldest outstanding write tag of that ID reports code 1 with `err_is_write`=1.
- R3: Reads with different IDs may retire in any order without error.
- R4: Writes with different IDs may retire in any order without error.
- R5: The read and write ID spaces are separate. An outstanding read never satisfies a B response of the same ID value, and an outstanding write never satisfies a read beat.
- R6: Only the beat with `r_last`=1 retires a read. Every beat, last or not, is checked against the oldest outstanding tag of its ID. A mismatching beat that is not last reports code 1 and leaves the entry outstanding.
- R7: A response whose ID has nothing outstanding in its direction reports code 2 (orphan).
- R8: Each ID holds at most DEPTH (default 8) outstanding transactions. A request beyond that reports code 3 (overflow) and is not recorded.
- R9: A channel transfer counts only when its valid and ready are both 1 at a rising clock edge.
- R10: The error is reported on the edge of the offending handshake as a single-cycle pulse. When `err_valid`=0, `err_code` is 0 (none).
- R11: When several errors occur in one cycle, exactly one is reported, by priority: read response, then write response, then read overflow, then write overflow.
- R12: A synchronous active-high reset clears every tracker and the error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | IW | Read address ID |
| ar_tag | input | TW | Label of the read request |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | IW | Read data ID |
| r_tag | input | TW | Label echoed by the read data |
| r_last | input | 1 | Final beat of a read |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | IW | Write address ID |
| aw_tag | input | TW | Label of the write request |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | input | IW | Write response ID |
| b_tag | input | TW | Label echoed by the write response |
| err_valid | output | 1 | Error pulse |
| err_code | output | 2 | 0 none, 1 order, 2 orphan, 3 overflow |
| err_id | output | IW | ID of the offending transfer |
| err_is_write | output | 1 | 1 if the error is on the write side |

## Verification
In-order streams on one ID must stay silent, while swapped last responses on one ID must flag. Interleaved completion across two IDs must stay silent, which separates a per-ID check from a global one. Reads and writes issued with the same ID value must not satisfy each other, which shows that the two ID spaces are kept apart. Further patterns cover:
- multi-beat reads, to show that only the last beat retires;
- stalled transfers with valid high and ready low;
- a ninth request on one ID, followed by draining that ID;
- simultaneous read and write errors, to check the reporting priority;
- a reset taken while entries are outstanding.

// File: rtl/axi_ord_pkg.sv
package axi_ord_pkg;
  typedef enum logic [1:0] {
    E_NONE     = 2'd0,
    E_ORDER    = 2'd1,
    E_ORPHAN   = 2'd2,
    E_OVERFLOW = 2'd3
  } ord_err_e;
endpackage

// File: rtl/ord_stream_tracker.sv
module ord_stream_tracker
  import axi_ord_pkg::*;
#(
  parameter int IW    = 4,
  parameter int TW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic [IW-1:0] push_id,
  input  logic [TW-1:0] push_tag,
  input  logic          resp_en,
  input  logic [IW-1:0] resp_id,
  input  logic [TW-1:0] resp_tag,
  input  logic          resp_last,
  output ord_err_e      resp_err,
  output logic          push_ovf
);
  localparam int NID = 1 << IW;
  localparam int PW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int MW  = IW + PW;
  localparam int MD  = NID << PW;

  // label storage: one slot group per ID, no reset so it maps to RAM
  logic [TW-1:0] tag_mem [MD];
  logic [PW-1:0] wptr [NID];
  logic [PW-1:0] rptr [NID];
  logic [CW-1:0] cnt  [NID];

  logic [TW-1:0] head_tag;
  logic          resp_empty;
  logic          pop;
  logic          push_full;
  logic          push_ok;
  logic [NID-1:0] inc_v, dec_v;

  assign head_tag   = tag_mem[MW'({resp_id, rptr[resp_id]})];
  assign resp_empty = (cnt[resp_id] == '0);
  assign pop        = resp_en && resp_last && !resp_empty;
  assign push_full  = (cnt[push_id] == CW'(DEPTH)) && !(pop && (resp_id == push_id));
  assign push_ok    = push_en && !push_full;
  assign push_ovf   = push_en && push_full;

  always_comb begin
    if (!resp_en)                resp_err = E_NONE;
    else if (resp_empty)         resp_err = E_ORPHAN;
    else if (resp_tag != head_tag) resp_err = E_ORDER;
    else                         resp_err = E_NONE;
  end

  always_comb begin
    for (int i = 0; i < NID; i++) begin
      inc_v[i] = push_ok && (push_id == IW'(i));
      dec_v[i] = pop && (resp_id == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) tag_mem[MW'({push_id, wptr[push_id]})] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NID; i++) begin
        wptr[i] <= '0;
        rptr[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NID; i++) begin
        if (inc_v[i]) wptr[i] <= (wptr[i] == PW'(DEPTH - 1)) ? '0 : wptr[i] + 1'b1;
        if (dec_v[i]) rptr[i] <= (rptr[i] == PW'(DEPTH - 1)) ? '0 : rptr[i] + 1'b1;
        case ({inc_v[i], dec_v[i]})
          2'b10:   cnt[i] <= cnt[i] + 1'b1;
          2'b01:   cnt[i] <= cnt[i] - 1'b1;
          default: cnt[i] <= cnt[i];
        endcase
      end
    end
  end
endmodule

// File: rtl/ord_err_select.sv
module ord_err_select
  import axi_ord_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  ord_err_e      rd_err,
  input  logic [IW-1:0] rd_id,
  input  ord_err_e      wr_err,
  input  logic [IW-1:0] wr_id,
  input  logic          rd_ovf,
  input  logic [IW-1:0] rd_ovf_id,
  input  logic          wr_ovf,
  input  logic [IW-1:0] wr_ovf_id,
  output logic          err_valid,
  output logic [1:0]    err_code,
  output logic [IW-1:0] err_id,
  output logic          err_is_write
);
  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid    <= 1'b0;
      err_code     <= E_NONE;
      err_id       <= '0;
      err_is_write <= 1'b0;
    end else if (rd_err != E_NONE) begin
      err_valid    <= 1'b1;
      err_code     <= rd_err;
      err_id       <= rd_id;
      err_is_write <= 1'b0;
    end else if (wr_err != E_NONE) begin
      err_valid    <= 1'b1;
      err_code     <= wr_err;
      err_id       <= wr_id;
      err_is_write <= 1'b1;
    end else if (rd_ovf) begin
      err_valid    <= 1'b1;
      err_code     <= E_OVERFLOW;
      err_id       <= rd_ovf_id;
      err_is_write <= 1'b0;
    end else if (wr_ovf) begin
      err_valid    <= 1'b1;
      err_code     <= E_OVERFLOW;
      err_id       <= wr_ovf_id;
      err_is_write <= 1'b1;
    end else begin
      err_valid    <= 1'b0;
      err_code     <= E_NONE;
      err_id       <= '0;
      err_is_write <= 1'b0;
    end
  end
endmodule

// File: rtl/axi_order_checker.sv
module axi_order_checker
  import axi_ord_pkg::*;
#(
  parameter int IW    = 4,
  parameter int TW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ar_valid,
  input  logic          ar_ready,
  input  logic [IW-1:0] ar_id,
  input  logic [TW-1:0] ar_tag,
  input  logic          r_valid,
  input  logic          r_ready,
  input  logic [IW-1:0] r_id,
  input  logic [TW-1:0] r_tag,
  input  logic          r_last,
  input  logic          aw_valid,
  input  logic          aw_ready,
  input  logic [IW-1:0] aw_id,
  input  logic [TW-1:0] aw_tag,
  input  logic          b_valid,
  input  logic          b_ready,
  input  logic [IW-1:0] b_id,
  input  logic [TW-1:0] b_tag,
  output logic          err_valid,
  output logic [1:0]    err_code,
  output logic [IW-1:0] err_id,
  output logic          err_is_write
);
  ord_err_e rd_err, wr_err;
  logic     rd_ovf, wr_ovf;

  ord_stream_tracker #(.IW(IW), .TW(TW), .DEPTH(DEPTH)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .push_en  (ar_valid && ar_ready),
    .push_id  (ar_id),
    .push_tag (ar_tag),
    .resp_en  (r_valid && r_ready),
    .resp_id  (r_id),
    .resp_tag (r_tag),
    .resp_last(r_last),
    .resp_err (rd_err),
    .push_ovf (rd_ovf)
  );

  ord_stream_tracker #(.IW(IW), .TW(TW), .DEPTH(DEPTH)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .push_en  (aw_valid && aw_ready),
    .push_id  (aw_id),
    .push_tag (aw_tag),
    .resp_en  (b_valid && b_ready),
    .resp_id  (b_id),
    .resp_tag (b_tag),
    .resp_last(1'b1),
    .resp_err (wr_err),
    .push_ovf (wr_ovf)
  );

  ord_err_select #(.IW(IW)) u_sel (
    .clk         (clk),
    .rst         (rst),
    .rd_err      (rd_err),
    .rd_id       (r_id),
    .wr_err      (wr_err),
    .wr_id       (b_id),
    .rd_ovf      (rd_ovf),
    .rd_ovf_id   (ar_id),
    .wr_ovf      (wr_ovf),
    .wr_ovf_id   (aw_id),
    .err_valid   (err_valid),
    .err_code    (err_code),
    .err_id      (err_id),
    .err_is_write(err_is_write)
  );
endmodule

// File: rtl/axi_order_checker_sva.sv
module axi_order_checker_sva #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ar_valid,
  input logic          ar_ready,
  input logic          r_valid,
  input logic          r_ready,
  input logic [IW-1:0] r_id,
  input logic          aw_valid,
  input logic          aw_ready,
  input logic          b_valid,
  input logic          b_ready,
  input logic [IW-1:0] b_id,
  input logic          err_valid,
  input logic [1:0]    err_code,
  input logic [IW-1:0] err_id,
  input logic          err_is_write
);
  // R1
  rd_err_src_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && !err_is_write && err_code != 2'd3) |->
      ($past(r_valid && r_ready) && err_id == $past(r_id)));

  // R2
  wr_err_src_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_is_write && err_code != 2'd3) |->
      ($past(b_valid && b_ready) && err_id == $past(b_id)));

  // R8
  ovf_src_chk: assert property (@(posedge clk) disable iff (rst)
    (err_valid && err_code == 2'd3) |->
      $past((ar_valid && ar_ready) || (aw_valid && aw_ready)));

  // R9
  no_hs_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !((ar_valid && ar_ready) || (r_valid && r_ready) ||
      (aw_valid && aw_ready) || (b_valid && b_ready)) |=> !err_valid);

  // R10
  idle_code_chk: assert property (@(posedge clk) disable iff (rst)
    !err_valid |-> (err_code == 2'd0));

  // R12
  rst_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> !err_valid);
endmodule

bind axi_order_checker axi_order_checker_sva #(.IW(IW)) u_sva (
  .clk(clk), .rst(rst),
  .ar_valid(ar_valid), .ar_ready(ar_ready),
  .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id),
  .aw_valid(aw_valid), .aw_ready(aw_ready),
  .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
  .err_valid(err_valid), .err_code(err_code),
  .err_id(err_id), .err_is_write(err_is_write)
);

// File: tb/axi_order_checker_tb.sv
`timescale 1ns/1ps
module axi_order_checker_tb;
  localparam int IW = 4;
  localparam int TW = 8;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ar_valid = 0, ar_ready = 0, r_valid = 0, r_ready = 0, r_last = 0;
  logic aw_valid = 0, aw_ready = 0, b_valid = 0, b_ready = 0;
  logic [IW-1:0] ar_id = 0, r_id = 0, aw_id = 0, b_id = 0;
  logic [TW-1:0] ar_tag = 0, r_tag = 0, aw_tag = 0, b_tag = 0;
  logic err_valid, err_is_write;
  logic [1:0] err_code;
  logic [IW-1:0] err_id;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic g_v, g_w;
  logic [1:0] g_c;
  logic [IW-1:0] g_id;

  always #4 clk = ~clk;

  axi_order_checker #(.IW(IW), .TW(TW), .DEPTH(DEPTH)) u_dut (.*);

  task automatic tick();
    @(negedge clk);
    g_v = err_valid; g_c = err_code; g_id = err_id; g_w = err_is_write;
    ar_valid = 0; ar_ready = 0; r_valid = 0; r_ready = 0; r_last = 0;
    aw_valid = 0; aw_ready = 0; b_valid = 0; b_ready = 0;
  endtask

  task automatic expect_err(string req, logic v, logic [1:0] c, logic [IW-1:0] id, logic w);
    total++;
    if (g_v !== v || g_c !== c || (v && (g_id !== id || g_w !== w))) begin
      bad++;
      $display("FAIL %s: got v=%0b code=%0d id=%0d wr=%0b exp v=%0b code=%0d id=%0d wr=%0b",
               req, g_v, g_c, g_id, g_w, v, c, id, w);
    end
  endtask

  task automatic expect_ok(string req);
    expect_err(req, 1'b0, 2'd0, '0, 1'b0);
  endtask

  task automatic do_ar(int id, int tag);
    ar_valid = 1; ar_ready = 1; ar_id = IW'(id); ar_tag = TW'(tag); tick();
  endtask
  task automatic do_aw(int id, int tag);
    aw_valid = 1; aw_ready = 1; aw_id = IW'(id); aw_tag = TW'(tag); tick();
  endtask
  task automatic do_r(int id, int tag, bit last);
    r_valid = 1; r_ready = 1; r_id = IW'(id); r_tag = TW'(tag); r_last = last; tick();
  endtask
  task automatic do_b(int id, int tag);
    b_valid = 1; b_ready = 1; b_id = IW'(id); b_tag = TW'(tag); tick();
  endtask

  task automatic apply_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic t_reset_state();
    tick(); expect_ok("R12 reset state");
  endtask

  task automatic t_read_order();
    do_ar(3, 10); expect_ok("R1 ar");
    do_ar(3, 11); expect_ok("R1 ar");
    do_r(3, 10, 1); expect_ok("R1 first in order");
    do_r(3, 11, 1); expect_ok("R1 second in order");
    do_ar(3, 20); do_ar(3, 21);
    do_r(3, 21, 1); expect_err("R1 swapped read", 1, 2'd1, 4'd3, 0);
    tick(); expect_ok("R10 pulse ends");
    apply_reset();
  endtask

  task automatic t_write_order();
    do_aw(7, 1); do_aw(7, 2);
    do_b(7, 1); expect_ok("R2 first in order");
    do_b(7, 2); expect_ok("R2 second in order");
    do_aw(7, 3); do_aw(7, 4);
    do_b(7, 4); expect_err("R2 swapped write", 1, 2'd1, 4'd7, 1);
    apply_reset();
  endtask

  task automatic t_cross_id();
    do_ar(1, 5); do_ar(2, 6);
    do_r(2, 6, 1); expect_ok("R3 later id first");
    do_r(1, 5, 1); expect_ok("R3 earlier id last");
    do_aw(1, 5); do_aw(2, 6);
    do_b(2, 6); expect_ok("R4 later id first");
    do_b(1, 5); expect_ok("R4 earlier id last");
  endtask

  task automatic t_spaces();
    do_ar(5, 7);
    do_b(5, 7); expect_err("R5 b vs outstanding read", 1, 2'd2, 4'd5, 1);
    do_r(5, 7, 1); expect_ok("R5 read still outstanding");
    do_aw(6, 8);
    do_r(6, 8, 1); expect_err("R5 r vs outstanding write", 1, 2'd2, 4'd6, 0);
    do_b(6, 8); expect_ok("R5 write still outstanding");
  endtask

  task automatic t_beats();
    do_ar(4, 1); do_ar(4, 2);
    do_r(4, 1, 0); expect_ok("R6 non-last beat");
    do_r(4, 1, 1); expect_ok("R6 last beat");
    do_r(4, 2, 1); expect_ok("R6 next read");
    do_ar(4, 3);
    do_r(4, 9, 0); expect_err("R6 bad non-last beat", 1, 2'd1, 4'd4, 0);
    do_r(4, 3, 1); expect_ok("R6 entry kept");
    do_r(4, 3, 1); expect_err("R7 orphan read", 1, 2'd2, 4'd4, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) begin
      do_aw(9, i); expect_ok("R8 fill");
    end
    do_aw(9, DEPTH); expect_err("R8 overflow", 1, 2'd3, 4'd9, 1);
    for (int i = 0; i < DEPTH; i++) begin
      do_b(9, i); expect_ok("R8 drain");
    end
    do_b(9, DEPTH); expect_err("R8 dropped request", 1, 2'd2, 4'd9, 1);
  endtask

  task automatic t_handshake();
    ar_valid = 1; ar_ready = 0; ar_id = 2; ar_tag = 1; tick();
    expect_ok("R9 stalled ar");
    r_valid = 1; r_ready = 0; r_id = 2; r_tag = 1; r_last = 1; tick();
    expect_ok("R9 stalled r");
    do_r(2, 1, 1); expect_err("R9 stalled ar not recorded", 1, 2'd2, 4'd2, 0);
  endtask

  task automatic t_priority();
    do_ar(1, 1);
    r_valid = 1; r_ready = 1; r_id = 1; r_tag = 9; r_last = 1;
    b_valid = 1; b_ready = 1; b_id = 1; b_tag = 0;
    tick(); expect_err("R11 read first", 1, 2'd1, 4'd1, 0);
    apply_reset();
  endtask

  task automatic t_reset_clear();
    do_ar(8, 1); do_aw(8, 1);
    apply_reset();
    expect_ok("R12 outputs after reset");
    do_r(8, 1, 1); expect_err("R12 read cleared", 1, 2'd2, 4'd8, 0);
    do_b(8, 1); expect_err("R12 write cleared", 1, 2'd2, 4'd8, 1);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 50000);
    total++; bad++;
    $display("FAIL watchdog: got timeout exp completion");
    report();
  end

  initial begin
    tick(); tick(); rst = 0;
    t_reset_state();
    t_read_order();
    t_write_order();
    t_cross_id();
    t_spaces();
    t_beats();
    t_overflow();
    t_handshake();
    t_priority();
    t_reset_clear();
    report();
  end
endmodule